// File: doc/BRIEF.md
# Legacy INTx and Bridge Event Interrupt Aggregator

This block gathers the four legacy INTx wires of a PCI Express root port and a set of single-cycle bridge and link event pulses into two interrupt groups. The legacy group shows the live level of each INTx wire. The event group latches each pulse into a sticky bit that stays set until software writes a 1 to it. Each group has its own enable register and drives its own interrupt output. One global enable bit gates both outputs.

Software reaches five word registers over a simple 32-bit write and read port. Writes take effect on the clock edge. Reads are combinational from the registered state. The logic that raises the individual events is outside this block.

Top module: `intx_evt_aggr`

## Requirements
- R1: The legacy status word at byte offset 0x00 has INTA in bit 0, INTB in bit 1, INTC in bit 2 and INTD in bit 3. One clock after a change on `intx_lvl`, each bit shows the level of that input. Writes to this offset have no effect.
- R2: The legacy enable word at offset 0x04 is read/write in bits 3:0, in the same positions as R1. It resets to 0. A 1 enables that line.
- R3: The event status word at offset 0x08 holds sticky bits. A pulse on an implemented bit of `evt_pulse` sets that bit on the next edge. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R4: When an event pulse and a write-1 clear of the same status bit fall in the same cycle, the bit stays set.
- R5: The implemented event bits are 0 (message available), 1 (message FIFO overflow), 4 (target error), 5 (initiator error), 6 (inbound translation error), 7 (outbound translation error), 16 (fatal AER), 17 (non-fatal AER), 18 (correctable AER), 20 (unsupported request), 22 (non-fatal device error), 23 (fatal device error), 24 (link down), 25 (autonomous bandwidth change) and 26 (bandwidth management). Together they form the mask 0x07D700F3. All other bits of the event status and event enable words read 0, ignore writes and ignore pulses.
- R6: The event enable word at offset 0x0C is read/write on the implemented bits of R5. It resets to 0. A 1 enables that event.
- R7: The global enable word at offset 0x10 is read/write in bit 0 and resets to 0. While it is 0, both `leg_irq` and `misc_irq` are low.
- R8: `leg_irq` is high exactly when the global enable is set and some bit is set in both the legacy status and the legacy enable. It stays high for as long as an enabled INTx level is held.
- R9: `misc_irq` is high exactly when the global enable is set and some bit is set in both the event status and the event enable.
- R10: After reset, every register reads 0 and both outputs are low. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_lvl | input | 4 | Legacy INTA..INTD levels, active high |
| evt_pulse | input | 32 | One-cycle event pulses, bit positions as in R5 |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| leg_irq | output | 1 | Legacy interrupt request |
| misc_irq | output | 1 | Event interrupt request |

## Verification
A new event pulse and a software write-1 clear of the same status bit can land in the same clock cycle. The bench drives a pulse on bit 24 together with a write that clears bits 16 to 26 at offset 0x08. It then expects bit 24 to read back set while the other cleared bits read 0, and expects `misc_irq` to stay high. The bench also drives a pulse on every bit position, including unused ones, and checks that only the implemented mask appears.

// File: rtl/iea_pkg.sv
package iea_pkg;
   localparam int unsigned IEA_DATA_W = 32;
   localparam int unsigned IEA_ADDR_W = 5;
   localparam int unsigned IEA_INTX_N = 4;

   // event bit map: data path and link events
   localparam logic [31:0] IEA_EVT_MAP =
      (32'h1 << 0)  | (32'h1 << 1)  | (32'h1 << 4)  | (32'h1 << 5)  |
      (32'h1 << 6)  | (32'h1 << 7)  | (32'h1 << 16) | (32'h1 << 17) |
      (32'h1 << 18) | (32'h1 << 20) | (32'h1 << 22) | (32'h1 << 23) |
      (32'h1 << 24) | (32'h1 << 25) | (32'h1 << 26);

   typedef enum logic [IEA_ADDR_W-1:0] {
      OFS_LEG_STAT = 5'h00,
      OFS_LEG_EN   = 5'h04,
      OFS_EVT_STAT = 5'h08,
      OFS_EVT_EN   = 5'h0C,
      OFS_GLB_EN   = 5'h10
   } iea_ofs_e;
endpackage

// File: rtl/iea_intx_track.sv
module iea_intx_track #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] stat_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("iea_intx_track: N must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= lvl_i;
   end
endmodule

// File: rtl/iea_rw_reg.sv
module iea_rw_reg #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] IMPL = '1,
   parameter logic [W-1:0] RSTV = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wd_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("iea_rw_reg: W must be at least 1");
      end
      if ((RSTV & ~IMPL) != '0) begin : g_bad_rst
         $error("iea_rw_reg: reset value touches unimplemented bits");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (IMPL[i]) begin : g_ff
            always_ff @(posedge clk) begin
               if (!rst_n)    q_o[i] <= RSTV[i];
               else if (we_i) q_o[i] <= wd_i[i];
            end
         end else begin : g_tie
            assign q_o[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/iea_w1c_bank.sv
module iea_w1c_bank #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("iea_w1c_bank: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (IMPL[i]) begin : g_ff
            always_ff @(posedge clk) begin
               if (!rst_n)        stat_o[i] <= 1'b0;
               else if (set_i[i]) stat_o[i] <= 1'b1;
               else if (clr_i[i]) stat_o[i] <= 1'b0;
            end

            // R4: a pulse always lands, even against a clear
            a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
               set_i[i] |=> stat_o[i]);
            // R3: sticky until a write-1 clear
            a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
               (stat_o[i] && !clr_i[i]) |=> stat_o[i]);
            // R3: clear without a pulse drops the bit
            a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_i[i] && !set_i[i]) |=> !stat_o[i]);
         end else begin : g_tie
            assign stat_o[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/iea_irq_gate.sv
module iea_irq_gate #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] en_i,
   input  logic         glb_i,
   output logic         irq_o
);
   always_comb irq_o = glb_i & (|(stat_i & en_i));
endmodule

// File: rtl/intx_evt_aggr.sv
module intx_evt_aggr
   import iea_pkg::*;
#(
   parameter int unsigned DATA_W  = IEA_DATA_W,
   parameter int unsigned ADDR_W  = IEA_ADDR_W,
   parameter int unsigned INTX_N  = IEA_INTX_N,
   parameter logic [DATA_W-1:0] EVT_MAP = IEA_EVT_MAP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INTX_N-1:0] intx_lvl,
   input  logic [DATA_W-1:0] evt_pulse,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              leg_irq,
   output logic              misc_irq
);
   localparam logic [DATA_W-1:0] LEG_IMPL = DATA_W'((64'h1 << INTX_N) - 1);

   generate
      if (INTX_N < 1 || INTX_N > DATA_W) begin : g_bad_intx
         $error("intx_evt_aggr: INTX_N out of range");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("intx_evt_aggr: ADDR_W too small for the map");
      end
   endgenerate

   logic              we_leg_en, we_evt_stat, we_evt_en, we_glb;
   logic [INTX_N-1:0] leg_stat, leg_en;
   logic [DATA_W-1:0] evt_stat, evt_en, evt_clr;
   logic [0:0]        glb_q;

   always_comb begin
      we_leg_en   = bus_wr && (bus_addr == ADDR_W'(OFS_LEG_EN));
      we_evt_stat = bus_wr && (bus_addr == ADDR_W'(OFS_EVT_STAT));
      we_evt_en   = bus_wr && (bus_addr == ADDR_W'(OFS_EVT_EN));
      we_glb      = bus_wr && (bus_addr == ADDR_W'(OFS_GLB_EN));
      evt_clr     = we_evt_stat ? bus_wdata : '0;
   end

   iea_intx_track #(.N(INTX_N)) u_intx (
      .clk(clk), .rst_n(rst_n), .lvl_i(intx_lvl), .stat_o(leg_stat));

   iea_rw_reg #(.W(INTX_N), .IMPL(LEG_IMPL[INTX_N-1:0]), .RSTV('0)) u_leg_en (
      .clk(clk), .rst_n(rst_n), .we_i(we_leg_en),
      .wd_i(bus_wdata[INTX_N-1:0]), .q_o(leg_en));

   iea_w1c_bank #(.W(DATA_W), .IMPL(EVT_MAP)) u_evt_stat (
      .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(evt_clr),
      .stat_o(evt_stat));

   iea_rw_reg #(.W(DATA_W), .IMPL(EVT_MAP), .RSTV('0)) u_evt_en (
      .clk(clk), .rst_n(rst_n), .we_i(we_evt_en), .wd_i(bus_wdata),
      .q_o(evt_en));

   iea_rw_reg #(.W(1), .IMPL(1'b1), .RSTV(1'b0)) u_glb (
      .clk(clk), .rst_n(rst_n), .we_i(we_glb), .wd_i(bus_wdata[0:0]),
      .q_o(glb_q));

   iea_irq_gate #(.W(INTX_N)) u_leg_gate (
      .stat_i(leg_stat), .en_i(leg_en), .glb_i(glb_q[0]), .irq_o(leg_irq));

   iea_irq_gate #(.W(DATA_W)) u_evt_gate (
      .stat_i(evt_stat), .en_i(evt_en), .glb_i(glb_q[0]), .irq_o(misc_irq));

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_LEG_STAT): bus_rdata[INTX_N-1:0] = leg_stat;
         ADDR_W'(OFS_LEG_EN):   bus_rdata[INTX_N-1:0] = leg_en;
         ADDR_W'(OFS_EVT_STAT): bus_rdata = evt_stat;
         ADDR_W'(OFS_EVT_EN):   bus_rdata = evt_en;
         ADDR_W'(OFS_GLB_EN):   bus_rdata[0] = glb_q[0];
         default:               bus_rdata = '0;
      endcase
   end

   // one cycle out of reset before history is meaningful
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1: legacy status follows the input one edge later
   a_r1_leg_follow: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (leg_stat == $past(intx_lvl)));
   // R7: global enable off forces both lines low
   a_r7_glb_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_q[0] |-> (!leg_irq && !misc_irq));
   // R5: unimplemented event bits never read back
   a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_stat | evt_en) & ~EVT_MAP) == '0);
   // R8: held enabled level keeps the legacy line up
   a_r8_leg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_irq && $stable(intx_lvl) && !we_leg_en && !we_glb) |=> leg_irq);
endmodule

// File: tb/intx_evt_aggr_tb_top.sv
module intx_evt_aggr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  intx_lvl = '0;
   logic [31:0] evt_pulse = '0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        leg_irq, misc_irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;  // 50 MHz

   intx_evt_aggr dut_i (
      .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .evt_pulse(evt_pulse),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .leg_irq(leg_irq), .misc_irq(misc_irq));

   // fields: intx, evt, wr, waddr, wdata, raddr, exp_rd, exp_leg, exp_misc, req
   localparam int NV = 13;
   localparam logic [120:0] VEC [NV] = '{
      {4'b0000, 32'h0, 1'b1, 5'h10, 32'h1, 5'h10, 32'h1, 1'b0, 1'b0, 8'd7},          // R7 enable
      {4'b0101, 32'h0, 1'b1, 5'h04, 32'hF, 5'h00, 32'h5, 1'b1, 1'b0, 8'd1},          // R1 INTA+INTC, R8
      {4'b0101, 32'h0, 1'b1, 5'h00, 32'hF, 5'h00, 32'h5, 1'b1, 1'b0, 8'd1},          // R1 write ignored
      {4'b0000, 32'h0, 1'b0, 5'h00, 32'h0, 5'h04, 32'hF, 1'b0, 1'b0, 8'd8},          // R8 level drop
      {4'b1000, 32'h0, 1'b1, 5'h04, 32'h7, 5'h04, 32'h7, 1'b0, 1'b0, 8'd2},          // R2 INTD masked
      {4'b1000, 32'hFFFFFFFF, 1'b0, 5'h00, 32'h0, 5'h08, 32'h07D700F3, 1'b0, 1'b0, 8'd5}, // R5 map
      {4'b1000, 32'h0, 1'b1, 5'h0C, 32'hFFFFFFFF, 5'h0C, 32'h07D700F3, 1'b0, 1'b1, 8'd6}, // R6, R9
      {4'b1000, 32'h0, 1'b1, 5'h08, 32'h000000F3, 5'h08, 32'h07D70000, 1'b0, 1'b1, 8'd3}, // R3 w1c
      {4'b1000, 32'h0, 1'b1, 5'h08, 32'h0, 5'h08, 32'h07D70000, 1'b0, 1'b1, 8'd3},   // R3 zeros
      {4'b1000, 32'h01000000, 1'b1, 5'h08, 32'h07D70000, 5'h08, 32'h01000000, 1'b0, 1'b1, 8'd4}, // R4
      {4'b0001, 32'h0, 1'b1, 5'h10, 32'h0, 5'h10, 32'h0, 1'b0, 1'b0, 8'd7},          // R7 gated
      {4'b0001, 32'h0, 1'b1, 5'h10, 32'h1, 5'h14, 32'h0, 1'b1, 1'b1, 8'd10},         // R10 unmapped
      {4'b0001, 32'h0, 1'b1, 5'h08, 32'hFFFFFFFF, 5'h08, 32'h0, 1'b1, 1'b0, 8'd9}    // R9 drop
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   initial begin
      #(20 * 5000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      for (int a = 0; a < 6; a++) read_chk("R10 reset read", 5'(a * 4), 32'h0);
      check("R10 leg_irq after reset", {31'h0, leg_irq}, 32'h0);
      check("R10 misc_irq after reset", {31'h0, misc_irq}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         logic [120:0] e;
         e = VEC[v];
         @(negedge clk);
         intx_lvl  = e[120:117];
         evt_pulse = e[116:85];
         bus_wr    = e[84];
         bus_addr  = e[83:79];
         bus_wdata = e[78:47];
         @(negedge clk);
         bus_wr    = 1'b0;
         evt_pulse = '0;
         read_chk($sformatf("R%0d vec %0d rdata", e[7:0], v), e[46:42], e[41:10]);
         check($sformatf("R%0d vec %0d leg_irq", e[7:0], v), {31'h0, leg_irq}, {31'h0, e[9]});
         check($sformatf("R%0d vec %0d misc_irq", e[7:0], v), {31'h0, misc_irq}, {31'h0, e[8]});
      end

      // R8: held level keeps the line up over several cycles
      repeat (4) @(negedge clk);
      check("R8 leg_irq held", {31'h0, leg_irq}, 32'h1);

      // R10: reset mid-run clears state, INTx still held
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk("R10 enable cleared", 5'h04, 32'h0);
      read_chk("R10 glb cleared", 5'h10, 32'h0);
      read_chk("R1 status after reset", 5'h00, 32'h1);
      check("R10 leg_irq after mid reset", {31'h0, leg_irq}, 32'h0);

      // R4 on a low bit, pulse with same-cycle clear
      @(negedge clk);
      evt_pulse = 32'h1;
      bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h1;
      @(negedge clk);
      bus_wr = 1'b0; evt_pulse = '0;
      read_chk("R4 bit0 survives clear", 5'h08, 32'h1);
      // R3 then a lone clear drops it
      bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h1;
      @(negedge clk);
      bus_wr = 1'b0;
      read_chk("R3 bit0 cleared", 5'h08, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule